// File: doc/BRIEF.md
# Three-Format 32-bit Single-Cycle Processor Core

This core runs one 32-bit instruction per clock. Each cycle it presents the program counter on the instruction port, decodes the word that comes back, reads two operands from a 32-entry register file, and does one of three things with the result. It can write a register, access data memory, or steer the program counter. Both memory ports are read combinationally within the cycle. Stores and register writes take effect at the next rising edge.

Three instruction layouts are supported. The register layout (opcode 0) carries a destination, a shift amount and a function code. The immediate layout carries a 16-bit constant. The jump layout carries a 26-bit word index. Every branch measures its offset from its own address, not from the next instruction. The two tests against zero share opcode 1, and the rt field selects which one applies. Any word the decoder does not recognise does nothing except advance the program counter, and it raises a flag during its own cycle.

Top module: `rsc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with parameter `START_PC`, so `imem_addr` equals `START_PC` in the first cycle after reset is released. `illegal` and `dmem_we` are low while `rst` is high.
- R2: An instruction that neither branches nor jumps advances the PC by 4.
- R3: Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], function [5:0], immediate [15:0]. Register ops with opcode 0 write rd and select on the function code: 33 ADDU rs+rt, 34 SUB rs-rt, 0 SLL rt<<shamt. Immediate ops write rt: 8 ADDI rs+sext(imm), 10 SLTI (signed rs < sext(imm) gives 1, otherwise 0), 15 LUI {imm,16'h0}.
- R4: LW (35) and SW (43) use the address rs+sext(imm). SW drives rt on `dmem_wdata` with `dmem_we` high. LW writes `dmem_rdata` into rt with `dmem_re` high. `dmem_we` and `dmem_re` are never high together.
- R5: BEQ (4) is taken when rs==rt. BNE (5) is taken when rs!=rt. The target is the branch's own address plus sext(imm)<<2.
- R6: Opcode 1 with rt=1 branches when rs is greater than or equal to zero (signed). With rt=0 it branches when rs is less than zero. The target is computed as in R5.
- R7: J (2) loads the PC with {PC[31:28], instr[25:0], 2'b00}. JR (opcode 0, function 8) loads the PC with rs.
- R8: Register 0 reads as zero, and writes to it are discarded.
- R9: An unknown opcode, an unknown function code under opcode 0, or opcode 1 with rt other than 0 or 1 writes neither a register nor memory. The PC advances by 4, and `illegal` is high for that cycle.
- R10: The program 0x00004021, 0x3c091001, 0x29010064, 0x10200005, 0xad280000, 0x21080001, 0x21290004, 0x0810000b, 0x03e00008, placed at 0x00400024, stores words 0..99 at 0x10010000 upward. It reaches the final JR after exactly 604 instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address, rs+sext(imm) |
| dmem_wdata | output | 32 | Store data (rt) |
| dmem_we | output | 1 | Store strobe, written at the next edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| illegal | output | 1 | Unrecognised instruction in this cycle |

## Verification
Register contents are not visible at the ports. Every arithmetic result therefore has to be stored to memory before it can be compared, and every branch outcome has to be read from the next fetch address. Each sweep case is a short generated program. It builds two full 32-bit operands with LUI followed by a sign-corrected ADDI, then branches or computes and stores the results. Operand pairs are swept over all combinations of eight corner values, and branch offsets cover both signs. The hardest state to reach is the loop exit on the hundredth pass. The counting program is run to completion, and both the instruction count and the hundred stored words are compared.

// File: rtl/rsc_core.sv
`timescale 1ns/1ps
module rsc_core #(
  parameter logic [31:0] START_PC = 32'h0040_0024
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata,
  output logic        illegal
);
  localparam logic [5:0] OP_RTYPE = 6'd0, OP_ZBR = 6'd1, OP_J = 6'd2, OP_BEQ = 6'd4,
                         OP_BNE = 6'd5, OP_ADDI = 6'd8, OP_SLTI = 6'd10, OP_LUI = 6'd15,
                         OP_LW = 6'd35, OP_SW = 6'd43;
  localparam logic [5:0] FN_SLL = 6'd0, FN_JR = 6'd8, FN_ADDU = 6'd33, FN_SUB = 6'd34;

  logic [31:0] pc, npc;
  logic [31:0] rf [32];

  wire [5:0]  op   = imem_rdata[31:26];
  wire [4:0]  rs   = imem_rdata[25:21];
  wire [4:0]  rt   = imem_rdata[20:16];
  wire [4:0]  rd   = imem_rdata[15:11];
  wire [4:0]  sh   = imem_rdata[10:6];
  wire [5:0]  fn   = imem_rdata[5:0];
  wire [15:0] imm  = imem_rdata[15:0];
  wire [31:0] imm_s = {{16{imm[15]}}, imm};

  wire [31:0] a = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] b = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] seq_pc = pc + 32'd4;
  wire [31:0] br_pc  = pc + {imm_s[29:0], 2'b00};

  logic        wen, st, ld, ill;
  logic [4:0]  wa;
  logic [31:0] wd;

  always_comb begin
    npc = seq_pc;
    wen = 1'b0;
    wa  = rt;
    wd  = 32'd0;
    st  = 1'b0;
    ld  = 1'b0;
    ill = 1'b0;
    unique case (op)
      OP_RTYPE: begin
        wa = rd;
        case (fn)
          FN_ADDU: begin wen = 1'b1; wd = a + b; end
          FN_SUB:  begin wen = 1'b1; wd = a - b; end
          FN_SLL:  begin wen = 1'b1; wd = b << sh; end
          FN_JR:   npc = a;
          default: ill = 1'b1;
        endcase
      end
      OP_ZBR: begin
        if (rt == 5'd1)      begin if (!a[31]) npc = br_pc; end
        else if (rt == 5'd0) begin if (a[31])  npc = br_pc; end
        else ill = 1'b1;
      end
      OP_J:    npc = {pc[31:28], imem_rdata[25:0], 2'b00};
      OP_BEQ:  if (a == b) npc = br_pc;
      OP_BNE:  if (a != b) npc = br_pc;
      OP_ADDI: begin wen = 1'b1; wd = a + imm_s; end
      OP_SLTI: begin wen = 1'b1; wd = {31'd0, $signed(a) < $signed(imm_s)}; end
      OP_LUI:  begin wen = 1'b1; wd = {imm, 16'd0}; end
      OP_LW:   begin wen = 1'b1; ld = 1'b1; wd = dmem_rdata; end
      OP_SW:   st = 1'b1;
      default: ill = 1'b1;
    endcase
  end

  assign imem_addr  = pc;
  assign dmem_addr  = a + imm_s;
  assign dmem_wdata = b;
  assign dmem_we    = st & ~rst;
  assign dmem_re    = ld & ~rst;
  assign illegal    = ill & ~rst;

  always_ff @(posedge clk) begin
    if (rst) pc <= START_PC;
    else     pc <= npc;
  end

  always_ff @(posedge clk) begin
    if (!rst && wen && wa != 5'd0) rf[wa] <= wd;
  end
endmodule

module rsc_core_chk #(
  parameter logic [31:0] START_PC = 32'h0040_0024
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        illegal
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> imem_addr == START_PC);
  // R4
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst) !(dmem_we && dmem_re));
  // R9
  illegal_no_store_chk: assert property (@(posedge clk) disable iff (rst) illegal |-> !dmem_we && !dmem_re);
  // R9
  illegal_seq_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> imem_addr == $past(imem_addr) + 32'd4);
  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_rdata[31:26] == 6'd2) |=>
      imem_addr == {$past(imem_addr[31:28]), $past(imem_rdata[25:0]), 2'b00});
endmodule

bind rsc_core rsc_core_chk #(.START_PC(START_PC)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_we(dmem_we), .dmem_re(dmem_re), .illegal(illegal)
);

// File: tb/tb_rsc_core.sv
`timescale 1ns/1ps
module tb_rsc_core;
  localparam logic [31:0] START = 32'h0040_0024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dm_clr = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we, dmem_re, illegal;
  logic [31:0] imem [64];
  logic [31:0] dmem [256];
  int total = 0, bad = 0, p = 0;

  always #2 clk = ~clk;

  rsc_core #(.START_PC(START)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .illegal(illegal)
  );

  wire [31:0] ioff = imem_addr - START;
  assign imem_rdata = (ioff < 32'd256) ? imem[ioff[7:2]] : 32'd0;
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dm_clr) begin
      for (int i = 0; i < 256; i++) dmem[i] <= 32'd0;
    end else if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    p = 0;
  endtask
  task automatic put(logic [31:0] w);
    imem[p] = w;
    p++;
  endtask
  task automatic ld32(int r, logic [31:0] v);
    logic [15:0] hi;
    hi = v[31:16] + {15'd0, v[15]};
    put(enc_i(15, 0, r, hi));
    put(enc_i(8, r, r, v[15:0]));
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dm_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; dm_clr = 1'b0;
  endtask
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  logic [31:0] vals [8];

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h0000_FFFF;
    vals[6] = 32'h1234_8000; vals[7] = 32'hDEAD_BEEF;

    // R1 / R2: reset state and sequential fetch over no-op words
    clear_prog();
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, START);
    chk("R1 illegal in reset", {31'd0, illegal}, 32'd0);
    chk("R1 we in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0; dm_clr = 1'b0;
    chk("R1 first pc", imem_addr, START);
    step(1);
    chk("R2 pc+4", imem_addr, START + 32'd4);
    step(3);
    chk("R2 pc+16", imem_addr, START + 32'd16);

    // R3: arithmetic sweep over all operand pairs
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] av, bv, iv;
        int sh;
        av = vals[i]; bv = vals[j];
        iv = {{16{vals[(i + j) % 8][15]}}, vals[(i + j) % 8][15:0]};
        sh = (i * 3 + j) % 32;
        clear_prog();
        ld32(1, av); ld32(2, bv);
        put(enc_r(1, 2, 3, 0, 33));
        put(enc_r(1, 2, 4, 0, 34));
        put(enc_i(10, 1, 5, iv[15:0]));
        put(enc_i(8, 1, 6, iv[15:0]));
        put(enc_r(0, 2, 7, sh, 0));
        put(enc_i(15, 0, 8, bv[15:0]));
        for (int k = 0; k < 6; k++) put(enc_i(43, 0, 3 + k, 16'(4 * k)));
        do_reset();
        step(p);
        chk("R3 addu", dmem[0], av + bv);
        chk("R3 sub", dmem[1], av - bv);
        chk("R3 slti", dmem[2], ($signed(av) < $signed(iv)) ? 32'd1 : 32'd0);
        chk("R3 addi", dmem[3], av + iv);
        chk("R3 sll", dmem[4], bv << sh);
        chk("R3 lui", dmem[5], {bv[15:0], 16'd0});
      end
    end

    // R4: store with negative offset, load back, modify, store again
    for (int i = 0; i < 8; i++) begin
      clear_prog();
      ld32(1, vals[i]);
      put(enc_i(8, 0, 2, 16'h0040));
      put(enc_i(43, 2, 1, 16'hFFFC));
      put(enc_i(35, 2, 8, 16'hFFFC));
      put(enc_i(8, 8, 8, 16'h0001));
      put(enc_i(43, 0, 8, 16'h0020));
      do_reset();
      step(4);
      chk("R4 load strobe", {31'd0, dmem_re}, 32'd1);
      chk("R4 load addr", dmem_addr, 32'h0000_003C);
      step(3);
      chk("R4 sw neg offset", dmem[15], vals[i]);
      chk("R4 lw then add", dmem[8], vals[i] + 32'd1);
    end

    // R5 / R6: branch outcomes and targets from own address
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] av, bv, expa;
        int off;
        bit tk;
        av = vals[i];
        bv = (j % 3 == 0) ? vals[i] : vals[j];
        off = (i * 5 + j) % 16 - 8;
        for (int kind = 0; kind < 4; kind++) begin
          clear_prog();
          ld32(1, av); ld32(2, bv);
          case (kind)
            0: begin put(enc_i(4, 1, 2, 16'(off))); tk = (av == bv); end
            1: begin put(enc_i(5, 1, 2, 16'(off))); tk = (av != bv); end
            2: begin put(enc_i(1, 1, 1, 16'(off))); tk = !av[31]; end
            default: begin put(enc_i(1, 1, 0, 16'(off))); tk = av[31]; end
          endcase
          do_reset();
          step(5);
          expa = START + 32'd16 + (tk ? 32'(off * 4) : 32'd4);
          if (kind < 2) chk("R5 cmp branch", imem_addr, expa);
          else          chk("R6 zero branch", imem_addr, expa);
        end
      end
    end

    // R7: J and JR
    for (int i = 0; i < 4; i++) begin
      logic [25:0] fld;
      logic [31:0] tgt;
      fld = 26'h0123457 * 26'(i + 1);
      clear_prog();
      put({6'd2, fld});
      do_reset();
      step(1);
      chk("R7 j target", imem_addr, {START[31:28], fld, 2'b00});
      tgt = {vals[i + 4][31:2], 2'b00};
      clear_prog();
      ld32(3, tgt);
      put(enc_r(3, 0, 0, 0, 8));
      do_reset();
      step(3);
      chk("R7 jr target", imem_addr, tgt);
    end

    // R8: register 0 stays zero
    clear_prog();
    put(enc_i(8, 0, 9, 16'h0003));
    put(enc_i(43, 0, 9, 16'h0028));
    put(enc_i(8, 0, 0, 16'h0005));
    put(enc_i(8, 0, 9, 16'h0003));
    put(enc_i(43, 0, 9, 16'h0024));
    put(enc_i(43, 0, 0, 16'h0028));
    do_reset();
    step(6);
    chk("R8 r0 reads zero", dmem[9], 32'd3);
    chk("R8 r0 store zero", dmem[10], 32'd0);

    // R9: illegal words act as no-ops
    clear_prog();
    put(enc_i(8, 0, 1, 16'h0007));
    put(enc_r(1, 1, 1, 0, 63));
    put(enc_i(1, 1, 3, 16'h0008));
    put(enc_i(63, 0, 1, 16'h0009));
    put(enc_i(43, 0, 1, 16'h0028));
    do_reset();
    chk("R9 legal no flag", {31'd0, illegal}, 32'd0);
    step(1);
    chk("R9 bad funct flag", {31'd0, illegal}, 32'd1);
    chk("R9 bad funct no store", {31'd0, dmem_we}, 32'd0);
    step(1);
    chk("R9 bad cond pc", imem_addr, START + 32'd8);
    chk("R9 bad cond flag", {31'd0, illegal}, 32'd1);
    step(1);
    chk("R9 not branched", imem_addr, START + 32'd12);
    chk("R9 bad op flag", {31'd0, illegal}, 32'd1);
    step(2);
    chk("R9 no reg write", dmem[10], 32'd7);

    // R10: counting loop image
    begin
      logic [31:0] img [9];
      int n;
      img[0] = 32'h00004021; img[1] = 32'h3c091001; img[2] = 32'h29010064;
      img[3] = 32'h10200005; img[4] = 32'had280000; img[5] = 32'h21080001;
      img[6] = 32'h21290004; img[7] = 32'h0810000b; img[8] = 32'h03e00008;
      clear_prog();
      for (int k = 0; k < 9; k++) put(img[k]);
      do_reset();
      n = 0;
      while (imem_addr != START + 32'd32 && n < 2000) begin
        step(1);
        n++;
      end
      chk("R10 instruction count", 32'(n), 32'd604);
      for (int k = 0; k < 100; k++) chk("R10 stored word", dmem[k], 32'(k));
      chk("R10 above array", dmem[100], 32'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule